// File: doc/BRIEF.md
# Serial Receive Idle Time-Out Detector

This block sits beside the receive path of a serial port. It watches two things: whether received characters are waiting unread in the receive queue, and whether new characters keep arriving. Unread data may sit in the queue with no new character for a set number of bit periods. When that happens, the block raises a time-out status level. The interrupt aggregator uses that level so that software collects a short tail of data that never reached the queue's fill trigger.

The block counts bit-period ticks from the baud generator and restarts the count on every new character. The limit is 32 bit periods in the standard mode and 64 bit periods when high-speed mode is selected. Once the status is set, it stays set until one of two things happens: the queue drains empty, or software writes a one to the clear strobe. After a software clear with data still waiting, the count starts over.

Top module: `rx_timeout_detect`

## Requirements
- R1: While `rst` is high at a rising clock edge, the status output `timeout_o` goes low and the idle count returns to zero.
- R2: When `fifo_nonempty_i` is low, bit-period ticks are not counted and `timeout_o` cannot rise. Counting starts from zero once data is present.
- R3: With `hs_mode_i` low (standard mode), `timeout_o` rises at the clock edge that takes in the 32nd tick since the count restarted. It stays low after 31 ticks. Clock cycles without `bit_tick_i` high do not advance the count.
- R4: With `hs_mode_i` high (high-speed mode), `timeout_o` rises at the clock edge that takes in the 64th tick. It stays low after 63 ticks.
- R5: A clock edge that sees `fifo_nonempty_i` low clears `timeout_o`. The output is low from the next cycle.
- R6: A clock edge that sees `sw_clear_i` high clears `timeout_o` and restarts the count from zero. This includes an edge where the final tick arrives together with the clear. With data still present, the status rises again only after a full new threshold of ticks.
- R7: A clock edge that sees `char_rx_i` high restarts the idle count from zero. It leaves an already set `timeout_o` unchanged.
- R8: The idle count saturates at the threshold and does not wrap. Extra ticks after the status rises leave `timeout_o` set. A later restart still needs a full threshold of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick_i | input | 1 | One-cycle pulse per serial bit period |
| fifo_nonempty_i | input | 1 | Receive queue holds at least one unread character |
| char_rx_i | input | 1 | One-cycle strobe when a new character is written to the queue |
| hs_mode_i | input | 1 | High-speed mode: 1 selects the 64-period limit, 0 the 32-period limit |
| sw_clear_i | input | 1 | One-cycle software clear of the time-out status |
| timeout_o | output | 1 | Registered time-out status level |

## Verification
The bench targets the exact edge where the threshold is crossed in each mode, one tick short and at the tick itself. A design with an off-by-one compare would rise a tick early or late. A design that shared one limit between modes would fire at 32 in high-speed mode. Other scenarios cover ticks arriving while the queue is empty, and a new character arriving partway through an interval. A design that counted while the queue was empty, or that did not restart the count on a new character, would rise early in those scenarios. The bench also sends a software clear in the same cycle as the crossing tick. Each clear is followed by a full re-count, to catch a clear that loses to a set or leaves the count where it was.

// File: rtl/rto_pkg.sv
package rto_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FAST = 1'b1
  } rto_mode_e;

  localparam int unsigned STD_BITS_DEF  = 32;
  localparam int unsigned FAST_BITS_DEF = 64;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/rto_limit_sel.sv
module rto_limit_sel
  import rto_pkg::*;
#(
  parameter int unsigned STD_BITS  = STD_BITS_DEF,
  parameter int unsigned FAST_BITS = FAST_BITS_DEF,
  parameter int unsigned W         = cnt_width(FAST_BITS)
) (
  input  logic         hs_mode_i,
  output logic [W-1:0] limit_o
);
  localparam logic [W-1:0] STD_LIM  = W'(STD_BITS);
  localparam logic [W-1:0] FAST_LIM = W'(FAST_BITS);

  rto_mode_e mode;
  assign mode = rto_mode_e'(hs_mode_i);

  always_comb begin
    unique case (mode)
      MODE_FAST: limit_o = FAST_LIM;
      default:   limit_o = STD_LIM;
    endcase
  end
endmodule

// File: rtl/rto_idle_counter.sv
module rto_idle_counter #(
  parameter int unsigned MAX_LIM = 64,
  parameter int unsigned W       = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  localparam logic [W:0] MAX_EXT = (W+1)'(MAX_LIM);

  logic [W-1:0] count_q;
  logic [W:0]   count_next_ext;

  assign count_next_ext = {1'b0, count_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      count_q <= '0;
    end else if (tick_i && (count_q < limit_i)) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign hit_o = !restart_i && tick_i && (count_next_ext == {1'b0, limit_i});

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (count_q == '0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, count_q} <= MAX_EXT));

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (count_q == '0));
endmodule

// File: rtl/rto_status_reg.sv
module rto_status_reg (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic nonempty_i,
  input  logic sw_clear_i,
  output logic flag_o
);
  logic drop;
  assign drop = sw_clear_i || !nonempty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else if (drop) begin
      flag_o <= 1'b0;
    end else if (hit_i) begin
      flag_o <= 1'b1;
    end
  end

  p_empty_clears_r5: assert property (@(posedge clk) disable iff (rst)
    !nonempty_i |=> !flag_o);

  p_sw_clear_r6: assert property (@(posedge clk) disable iff (rst)
    sw_clear_i |=> !flag_o);

  p_rise_on_hit_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(hit_i));

  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !flag_o);
endmodule

// File: rtl/rx_timeout_detect.sv
module rx_timeout_detect
  import rto_pkg::*;
#(
  parameter int unsigned STD_BITS  = STD_BITS_DEF,
  parameter int unsigned FAST_BITS = FAST_BITS_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick_i,
  input  logic fifo_nonempty_i,
  input  logic char_rx_i,
  input  logic hs_mode_i,
  input  logic sw_clear_i,
  output logic timeout_o
);
  localparam int unsigned MAX_LIM = (FAST_BITS > STD_BITS) ? FAST_BITS : STD_BITS;
  localparam int unsigned W       = cnt_width(MAX_LIM);

  logic [W-1:0] limit;
  logic         restart;
  logic         hit;

  assign restart = char_rx_i || !fifo_nonempty_i || sw_clear_i;

  rto_limit_sel #(
    .STD_BITS (STD_BITS),
    .FAST_BITS(FAST_BITS),
    .W        (W)
  ) u_lim (
    .hs_mode_i(hs_mode_i),
    .limit_o  (limit)
  );

  rto_idle_counter #(
    .MAX_LIM(MAX_LIM),
    .W      (W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .restart_i(restart),
    .tick_i   (bit_tick_i),
    .limit_i  (limit),
    .hit_o    (hit)
  );

  rto_status_reg u_flag (
    .clk       (clk),
    .rst       (rst),
    .hit_i     (hit),
    .nonempty_i(fifo_nonempty_i),
    .sw_clear_i(sw_clear_i),
    .flag_o    (timeout_o)
  );

  p_empty_no_count_r2: assert property (@(posedge clk) disable iff (rst)
    !fifo_nonempty_i |-> !hit);
endmodule

// File: tb/sim_rx_timeout_detect.sv
module sim_rx_timeout_detect;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst;
  logic bit_tick_i, fifo_nonempty_i, char_rx_i, hs_mode_i, sw_clear_i;
  logic timeout_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_timeout_detect u0 (
    .clk(clk), .rst(rst), .bit_tick_i(bit_tick_i),
    .fifo_nonempty_i(fifo_nonempty_i), .char_rx_i(char_rx_i),
    .hs_mode_i(hs_mode_i), .sw_clear_i(sw_clear_i), .timeout_o(timeout_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: timeout_o actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick_i = 1'b1;
      @(negedge clk) bit_tick_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk) sw_clear_i = 1'b1;
    @(negedge clk) sw_clear_i = 1'b0;
  endtask

  task automatic pulse_char();
    @(negedge clk) char_rx_i = 1'b1;
    @(negedge clk) char_rx_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk) fifo_nonempty_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; bit_tick_i = 0; fifo_nonempty_i = 0; char_rx_i = 0;
    hs_mode_i = 0; sw_clear_i = 0;
    idle(3);
    @(negedge clk) rst = 1'b0;
    check("R1 reset low", timeout_o, 1'b0);
  endtask

  task automatic t_std_threshold();
    fifo_nonempty_i = 1'b1; hs_mode_i = 1'b0;
    ticks(31);
    idle(20);
    check("R3 std 31 ticks plus idle cycles", timeout_o, 1'b0);
    ticks(1);
    check("R3 std 32nd tick", timeout_o, 1'b1);
  endtask

  task automatic t_drain();
    drain();
    check("R5 drain clears", timeout_o, 1'b0);
  endtask

  task automatic t_empty_no_count();
    fifo_nonempty_i = 1'b0;
    ticks(40);
    check("R2 empty no rise", timeout_o, 1'b0);
    @(negedge clk) fifo_nonempty_i = 1'b1;
    ticks(31);
    check("R2 fresh count after data", timeout_o, 1'b0);
    ticks(1);
    check("R2 rise after full count", timeout_o, 1'b1);
    drain();
  endtask

  task automatic t_fast_threshold();
    @(negedge clk) begin hs_mode_i = 1'b1; fifo_nonempty_i = 1'b1; end
    ticks(63);
    check("R4 fast 63 ticks", timeout_o, 1'b0);
    ticks(1);
    check("R4 fast 64th tick", timeout_o, 1'b1);
    drain();
    @(negedge clk) hs_mode_i = 1'b0;
  endtask

  task automatic t_sw_clear();
    @(negedge clk) fifo_nonempty_i = 1'b1;
    ticks(32);
    check("R6 set before clear", timeout_o, 1'b1);
    pulse_clear();
    check("R6 clear lowers", timeout_o, 1'b0);
    ticks(31);
    check("R6 no early re-rise", timeout_o, 1'b0);
    ticks(1);
    check("R6 re-rise after full count", timeout_o, 1'b1);
    pulse_clear();
    ticks(31);
    @(negedge clk) begin bit_tick_i = 1'b1; sw_clear_i = 1'b1; end
    @(negedge clk) begin bit_tick_i = 1'b0; sw_clear_i = 1'b0; end
    check("R6 clear wins over crossing tick", timeout_o, 1'b0);
    ticks(31);
    check("R6 count restarted by clear", timeout_o, 1'b0);
    drain();
  endtask

  task automatic t_char_restart();
    @(negedge clk) fifo_nonempty_i = 1'b1;
    ticks(20);
    pulse_char();
    ticks(20);
    check("R7 char restarts count", timeout_o, 1'b0);
    ticks(12);
    check("R7 rise 32 after char", timeout_o, 1'b1);
    pulse_char();
    check("R7 char keeps flag", timeout_o, 1'b1);
  endtask

  task automatic t_saturate();
    ticks(100);
    check("R8 flag holds after extra ticks", timeout_o, 1'b1);
    pulse_clear();
    ticks(31);
    check("R8 full count after saturation", timeout_o, 1'b0);
    ticks(1);
    check("R8 rise after full count", timeout_o, 1'b1);
    drain();
  endtask

  initial begin
    t_reset();
    t_std_threshold();
    t_drain();
    t_empty_no_count();
    t_fast_threshold();
    t_sw_clear();
    t_char_restart();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule